// File: doc/BRIEF.md
# Shared-Bus Ownership Handover Controller

This block sits beside the default owner of a shared bus and manages the handover of that bus to external masters such as DMA engines or co-processors. External masters ask for the bus on an active-low request wire and confirm that they have taken it on an active-low acknowledge wire. Both wires are shared by all requesters as open-drain lines with pull-ups. The controller answers on an active-low grant wire. It never cuts a local transfer short: the grant may be given while the local master is still mid-cycle, but ownership is released only after that cycle has completed.

The ownership output drives the enables of the local address, data, strobe and read/write drivers. When it is low, those drivers must be in high impedance. A hold output tells the local master to start no new cycles, and it stays asserted until ownership returns. The two shared wires are asynchronous to the local clock, so each passes through a two-stage synchronizer before the state machine sees it. The local busy input is in the local clock domain and is used as it arrives.

Top module: `bus_arb_ctl`

## Requirements
- R1: After reset, the grant output is high (not granted), the ownership output is high (local owns the bus) and the hold output is low.
- R2: A request line held low is seen after two synchronizer edges. The grant output goes low on the third rising clock edge after the request goes low, and not before.
- R3: The hold output goes high together with the grant. It stays high until local ownership is restored.
- R4: While the grant is asserted, ownership stays high for as long as the local busy input is high. Ownership falls on the first rising edge at which the busy input is sampled low in the granted state.
- R5: After ownership has been released, an acknowledge line held low deasserts the grant on the third rising edge. Ownership then stays low for as long as the acknowledge stays low, whatever the request line does.
- R6: If the request returns high before any acknowledge, the grant deasserts on the third rising edge after that change, and ownership is high at that point with hold low. This applies both while the local cycle is still running and after the release.
- R7: When the acknowledge returns high while the request is high, ownership returns on the third rising edge after the acknowledge rises, and hold goes low.
- R8: When the acknowledge returns high while the request is still low, ownership does not return. A new grant appears on the third rising edge after the acknowledge rises.
- R9: An acknowledge pulse while no grant is outstanding is ignored. Ownership stays high, the grant stays high and hold stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| breq_n_i | input | 1 | Shared bus request, active low, asynchronous |
| back_n_i | input | 1 | Shared grant acknowledge, active low, asynchronous |
| loc_busy_i | input | 1 | High while the local master has a bus cycle in progress |
| bgnt_n_o | output | 1 | Bus grant, active low |
| own_o | output | 1 | High while the local master owns the bus; enables the local drivers |
| hold_o | output | 1 | High while the local master must not start a new cycle |

## Verification
The shared-wire responses (grant assertion, grant removal and ownership return) all arrive on the third rising edge after the wire changes: two edges in the synchronizer and one in the state register. The release of ownership follows the falling edge of the local busy input one edge later. The bench changes inputs on falling clock edges and counts falling edges before it samples. For each such response it checks the output once a cycle early, when the old value must still be present, and once exactly at the due cycle. This pins down the latency in both directions rather than only showing that the response eventually happens.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic [1:0] {
    ST_LOCAL    = 2'd0,
    ST_GNT_BUSY = 2'd1,
    ST_GNT_FREE = 2'd2,
    ST_EXTERNAL = 2'd3
  } arb_state_t;
endpackage

// File: rtl/arb_sync.sv
module arb_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      chain[s] <= RST_VAL;
      else if (s == 0) chain[s] <= d_i;
      else             chain[s] <= chain[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/arb_fsm.sv
module arb_fsm
  import arb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_s,
  input  logic ack_s,
  input  logic loc_busy_i,
  output logic bgnt_n_o,
  output logic own_o,
  output logic hold_o
);
  arb_state_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_LOCAL:    if (req_s) st_d = ST_GNT_BUSY;
      ST_GNT_BUSY: begin
        if (!req_s)          st_d = ST_LOCAL;
        else if (!loc_busy_i) st_d = ST_GNT_FREE;
      end
      ST_GNT_FREE: begin
        if (ack_s)       st_d = ST_EXTERNAL;
        else if (!req_s) st_d = ST_LOCAL;
      end
      ST_EXTERNAL: begin
        if (!ack_s) st_d = req_s ? ST_GNT_FREE : ST_LOCAL;
      end
      default:     st_d = ST_LOCAL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_LOCAL;
    else        st_q <= st_d;
  end

  assign bgnt_n_o = !((st_q == ST_GNT_BUSY) || (st_q == ST_GNT_FREE));
  assign own_o    = (st_q == ST_LOCAL) || (st_q == ST_GNT_BUSY);
  assign hold_o   = (st_q != ST_LOCAL);

  // R2: grant only follows a synchronized request
  a_r2_grant_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bgnt_n_o) |-> $past(req_s));

  // R3: hold raised only in answer to a request
  a_r3_hold_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_o) |-> $past(req_s));

  // R4: ownership never dropped during a local cycle
  a_r4_release_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(own_o) |-> !$past(loc_busy_i));

  // R5: acknowledge after release removes grant and keeps drivers off
  a_r5_ack_drops_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_GNT_FREE && ack_s) |=> (bgnt_n_o && !own_o));

  // R7: ownership only returns with both shared wires idle
  a_r7_return_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(own_o) |-> $past(!ack_s && !req_s));

  // R9: acknowledge alone never moves the controller out of local ownership
  a_r9_stray_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_LOCAL && !req_s) |=> own_o && bgnt_n_o);
endmodule

// File: rtl/bus_arb_ctl.sv
module bus_arb_ctl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic breq_n_i,
  input  logic back_n_i,
  input  logic loc_busy_i,
  output logic bgnt_n_o,
  output logic own_o,
  output logic hold_o
);
  localparam int NWIRE = 2;

  logic [NWIRE-1:0] wire_raw_n, wire_sync_n;
  logic             req_s, ack_s;

  assign wire_raw_n = {back_n_i, breq_n_i};

  arb_sync #(.W(NWIRE), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (wire_raw_n),
    .q_o   (wire_sync_n)
  );

  assign req_s = !wire_sync_n[0];
  assign ack_s = !wire_sync_n[1];

  arb_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_s      (req_s),
    .ack_s      (ack_s),
    .loc_busy_i (loc_busy_i),
    .bgnt_n_o   (bgnt_n_o),
    .own_o      (own_o),
    .hold_o     (hold_o)
  );
endmodule

// File: tb/bus_arb_ctl_tb.sv
module bus_arb_ctl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic breq_n = 1'b1, back_n = 1'b1, busy = 1'b0;
  logic bgnt_n, own, hold;
  int   n_chk = 0, n_fail = 0;
  bit   done = 1'b0;

  always #2.5 clk = ~clk;

  bus_arb_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .breq_n_i(breq_n), .back_n_i(back_n),
    .loc_busy_i(busy), .bgnt_n_o(bgnt_n), .own_o(own), .hold_o(hold)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic chk3(input string req, input logic eg, input logic eo, input logic eh);
    chk(req, "bgnt_n", bgnt_n, eg);
    chk(req, "own", own, eo);
    chk(req, "hold", hold, eh);
  endtask

  task automatic t_reset();
    cyc(1);
    chk3("R1", 1'b1, 1'b1, 1'b0);
  endtask

  // R2 R3 R4 R5 R7: full handover with local cycle in progress
  task automatic t_full_handover();
    busy = 1'b1; breq_n = 1'b0;
    cyc(2); chk("R2", "grant early", bgnt_n, 1'b1);
    cyc(1); chk3("R2", 1'b0, 1'b1, 1'b1);
    chk("R3", "hold with grant", hold, 1'b1);
    cyc(3); chk("R4", "own while busy", own, 1'b1);
    busy = 1'b0;
    cyc(1); chk("R4", "own after busy drop", own, 1'b0);
    chk("R4", "grant kept", bgnt_n, 1'b0);
    back_n = 1'b0;
    cyc(2); chk("R5", "grant before ack seen", bgnt_n, 1'b0);
    cyc(1); chk("R5", "grant removed", bgnt_n, 1'b1);
    chk("R5", "own low", own, 1'b0);
    breq_n = 1'b1;
    cyc(5); chk("R5", "own low during ack", own, 1'b0);
    chk("R3", "hold during ack", hold, 1'b1);
    back_n = 1'b1;
    cyc(2); chk("R7", "own early", own, 1'b0);
    cyc(1); chk3("R7", 1'b1, 1'b1, 1'b0);
  endtask

  // R6: request withdrawn after release, before acknowledge
  task automatic t_withdraw_free();
    breq_n = 1'b0;
    cyc(3); chk("R2", "grant idle", bgnt_n, 1'b0);
    chk("R4", "own one edge", own, 1'b1);
    cyc(1); chk("R4", "release when idle", own, 1'b0);
    breq_n = 1'b1;
    cyc(2); chk("R6", "grant still", bgnt_n, 1'b0);
    chk("R6", "own still low", own, 1'b0);
    cyc(1); chk3("R6", 1'b1, 1'b1, 1'b0);
  endtask

  // R6: request withdrawn while local cycle still runs
  task automatic t_withdraw_busy();
    busy = 1'b1; breq_n = 1'b0;
    cyc(3); chk3("R6", 1'b0, 1'b1, 1'b1);
    breq_n = 1'b1;
    cyc(3); chk3("R6", 1'b1, 1'b1, 1'b0);
    busy = 1'b0;
    cyc(2); chk("R6", "own after busy end", own, 1'b1);
  endtask

  // R8: second requester keeps request low across acknowledge release
  task automatic t_back_to_back();
    breq_n = 1'b0;
    cyc(4); chk("R8", "released", own, 1'b0);
    back_n = 1'b0;
    cyc(3); chk("R8", "grant off", bgnt_n, 1'b1);
    back_n = 1'b1;
    cyc(2); chk("R8", "no grant yet", bgnt_n, 1'b1);
    cyc(1); chk3("R8", 1'b0, 1'b0, 1'b1);
    cyc(2); chk("R8", "own stays low", own, 1'b0);
    breq_n = 1'b1;
    cyc(3); chk3("R6", 1'b1, 1'b1, 1'b0);
  endtask

  // R9: stray acknowledge with no grant outstanding
  task automatic t_stray_ack();
    back_n = 1'b0;
    cyc(5); chk3("R9", 1'b1, 1'b1, 1'b0);
    back_n = 1'b1;
    cyc(3); chk3("R9", 1'b1, 1'b1, 1'b0);
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    t_reset();
    t_full_handover();
    t_withdraw_free();
    t_withdraw_busy();
    t_back_to_back();
    t_stray_ack();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule